// File: doc/BRIEF.md
# SIMD Floating-Point Exception Trap Sequencer

This block is the control state machine that walks one SIMD floating-point instruction through its exception checks. When an instruction starts, the sequencer first examines the input-side conditions: invalid, denormal operand and divide-by-zero. If any of them is unmasked, it requests a trap and waits for the handler to return. It then examines the result-side conditions (overflow, underflow, precision) and may trap a second time. Only when no unmasked condition is pending does it pulse the commit and destination-write strobes.

Every detected condition, masked or not, is ORed into a sticky flag register. Only an explicit write clears that register. The kind of trap depends on an operating-system support bit, which sits at bit 10 of the system control register and enters the block as a single input. When that bit is set, the sequencer raises a SIMD floating-point exception trap. When it is clear, it raises an invalid-opcode trap, which ends the instruction without a commit. The arithmetic datapath and the handler software lie outside the block: the datapath appears as condition bits and the handler as a return pulse. The legacy FPU error pin is never driven, and the legacy ignore-error input is not used.

Top module: `simd_fp_trap_seq`

## Requirements
- R1: During and after reset, all trap, commit and write-enable outputs are 0 and `flags_o` is 0.
- R2: Two cycles after a `start_i` cycle, if any input-side condition is unmasked (condition bit 1 and its mask bit 0) and `os_en_i` is 1, `trap_xm_o` pulses for exactly one cycle. No commit follows until `hdl_ret_i` has been seen.
- R3: If an unmasked condition is found while `os_en_i` is 0, `trap_ud_o` pulses for one cycle instead. The instruction ends with no commit and no destination write, and the block returns to idle.
- R4: With no unmasked condition, `commit_o` and `dest_we_o` are 1 for exactly one cycle, three cycles after the `start_i` cycle.
- R5: Result-side conditions are examined only after the input-side phase finishes: after the handler returns, or at once when that phase raised no trap. An instruction with unmasked conditions in both phases produces two `trap_xm_o` pulses and commits after the second handler return.
- R6: All detected result-side conditions are ORed into the flags before the trap becomes visible. `dest_we_o` stays 0 while the trap is outstanding.
- R7: When masked and unmasked conditions occur together, flags for both are set. The commit follows only the return from the result-side handler.
- R8: Masked conditions set their sticky flags but never cause a trap.
- R9: Flags bit layout: [0] invalid, [1] denormal, [2] divide-by-zero, [3] overflow, [4] underflow, [5] precision. The same layout is used for `mask_i`, and `pre_cond_i`/`post_cond_i` map onto bits [2:0]/[5:3]. Flags are cleared only by `flag_wr_i`, which loads `flag_wr_data_i` one cycle later. Conditions detected in the same cycle are ORed on top of the written value.
- R10: `legacy_err_o` is always 0, and `legacy_ign_i` has no effect on any output.
- R11: A trap pulse lasts one cycle. The sequencer waits indefinitely in the trap state until `hdl_ret_i` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin sequencing one instruction |
| pre_cond_i | input | 3 | Input-side conditions: invalid, denormal, divide-by-zero |
| post_cond_i | input | 3 | Result-side conditions: overflow, underflow, precision |
| mask_i | input | 6 | Mask bits, 1 = masked |
| flag_wr_i | input | 1 | Explicit sticky-flag write |
| flag_wr_data_i | input | 6 | Value loaded by a flag write |
| os_en_i | input | 1 | OS support bit (bit 10 of system control register) |
| hdl_ret_i | input | 1 | Handler-return pulse |
| legacy_ign_i | input | 1 | Legacy ignore-error input, not used |
| trap_ud_o | output | 1 | Invalid-opcode trap pulse |
| trap_xm_o | output | 1 | SIMD floating-point trap pulse |
| commit_o | output | 1 | Instruction completion strobe |
| dest_we_o | output | 1 | Destination register write enable |
| flags_o | output | 6 | Sticky exception flags |
| legacy_err_o | output | 1 | Legacy FPU error output, held low |

## Verification
A sequencer stuck in a wait state shows up as a missing commit after `hdl_ret_i`, seen within one or two cycles of the return. A skipped phase shows up as a commit that arrives a cycle early, or as a missing second `trap_xm_o` pulse. A wrong trap-type choice is visible on the trap outputs at the second cycle after start. Flag corruption is visible on `flags_o` in the cycle after the check phase, and a lost sticky bit is visible on the next instruction, which must leave the flags unchanged.

// File: rtl/simd_exc_pkg.sv
package simd_exc_pkg;
    localparam int PHASE_N = 3;
    localparam int COND_N  = 2 * PHASE_N;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE_CHECK,
        SQ_PRE_TRAP_WAIT,
        SQ_POST_CHECK,
        SQ_POST_TRAP_WAIT,
        SQ_COMMIT
    } seq_state_e;

    typedef struct packed {
        logic              hit;
        logic [COND_N-1:0] seen;
    } phase_eval_t;

    function automatic logic live_any(input logic [PHASE_N-1:0] cond,
                                      input logic [PHASE_N-1:0] msk);
        return |(cond & ~msk);
    endfunction
endpackage

// File: rtl/simd_exc_eval.sv
module simd_exc_eval
    import simd_exc_pkg::*;
(
    input  seq_state_e          state,
    input  logic [PHASE_N-1:0]  pre_cond,
    input  logic [PHASE_N-1:0]  post_cond,
    input  logic [COND_N-1:0]   mask,
    output phase_eval_t         res
);
    always_comb begin
        res = '0;
        unique case (state)
            SQ_PRE_CHECK: begin
                res.seen = {{PHASE_N{1'b0}}, pre_cond};
                res.hit  = live_any(pre_cond, mask[PHASE_N-1:0]);
            end
            SQ_POST_CHECK: begin
                res.seen = {post_cond, {PHASE_N{1'b0}}};
                res.hit  = live_any(post_cond, mask[COND_N-1:PHASE_N]);
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/simd_exc_sticky.sv
module simd_exc_sticky
    import simd_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [COND_N-1:0] wr_data,
    input  logic [COND_N-1:0] set_bits,
    output logic [COND_N-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (wr ? wr_data : flags) | set_bits;
    end
endmodule

// File: rtl/simd_exc_fsm.sv
module simd_exc_fsm
    import simd_exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       hit,
    input  logic       os_en,
    input  logic       hdl_ret,
    output seq_state_e state,
    output logic       trap_ud,
    output logic       trap_xm,
    output logic       commit
);
    seq_state_e nxt;
    logic       checking;

    assign checking = (state == SQ_PRE_CHECK) || (state == SQ_POST_CHECK);

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:           if (start) nxt = SQ_PRE_CHECK;
            SQ_PRE_CHECK:      nxt = !hit ? SQ_POST_CHECK :
                                     (os_en ? SQ_PRE_TRAP_WAIT : SQ_IDLE);
            SQ_PRE_TRAP_WAIT:  if (hdl_ret) nxt = SQ_POST_CHECK;
            SQ_POST_CHECK:     nxt = !hit ? SQ_COMMIT :
                                     (os_en ? SQ_POST_TRAP_WAIT : SQ_IDLE);
            SQ_POST_TRAP_WAIT: if (hdl_ret) nxt = SQ_COMMIT;
            SQ_COMMIT:         nxt = SQ_IDLE;
            default:           nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            trap_ud <= 1'b0;
            trap_xm <= 1'b0;
        end else begin
            state   <= nxt;
            trap_ud <= checking && hit && !os_en;
            trap_xm <= checking && hit && os_en;
        end
    end

    assign commit = (state == SQ_COMMIT);
endmodule

// File: rtl/simd_fp_trap_seq.sv
module simd_fp_trap_seq
    import simd_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PHASE_N-1:0] pre_cond_i,
    input  logic [PHASE_N-1:0] post_cond_i,
    input  logic [COND_N-1:0] mask_i,
    input  logic              flag_wr_i,
    input  logic [COND_N-1:0] flag_wr_data_i,
    input  logic              os_en_i,
    input  logic              hdl_ret_i,
    input  logic              legacy_ign_i,
    output logic              trap_ud_o,
    output logic              trap_xm_o,
    output logic              commit_o,
    output logic              dest_we_o,
    output logic [COND_N-1:0] flags_o,
    output logic              legacy_err_o
);
    seq_state_e  state;
    phase_eval_t ev;
    logic        commit_w;

    simd_exc_eval u_eval (
        .state     (state),
        .pre_cond  (pre_cond_i),
        .post_cond (post_cond_i),
        .mask      (mask_i),
        .res       (ev)
    );

    simd_exc_sticky u_sticky (
        .clk      (clk),
        .rst      (rst),
        .wr       (flag_wr_i),
        .wr_data  (flag_wr_data_i),
        .set_bits (ev.seen),
        .flags    (flags_o)
    );

    simd_exc_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .hit     (ev.hit),
        .os_en   (os_en_i),
        .hdl_ret (hdl_ret_i),
        .state   (state),
        .trap_ud (trap_ud_o),
        .trap_xm (trap_xm_o),
        .commit  (commit_w)
    );

    assign commit_o     = commit_w;
    assign dest_we_o    = commit_w;
    assign legacy_err_o = 1'b0;
endmodule

// File: rtl/simd_exc_seq_chk.sv
module simd_exc_seq_chk
    import simd_exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flag_wr_i,
    input logic              legacy_ign_i,
    input logic              trap_ud_o,
    input logic              trap_xm_o,
    input logic              commit_o,
    input logic              dest_we_o,
    input logic [COND_N-1:0] flags_o,
    input logic              legacy_err_o
);
    AST_ONE_TRAP_KIND: assert property (@(posedge clk) disable iff (rst)
        !(trap_ud_o && trap_xm_o)); // R3

    AST_XM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        trap_xm_o |=> !trap_xm_o); // R11

    AST_UD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        trap_ud_o |=> !commit_o && !dest_we_o); // R3

    AST_XM_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        trap_xm_o |-> !commit_o && !dest_we_o); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(flag_wr_i) |-> ((flags_o & $past(flags_o)) == $past(flags_o))); // R9

    AST_ERR_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        $changed(legacy_ign_i) |=> !legacy_err_o); // R10
endmodule

bind simd_fp_trap_seq simd_exc_seq_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .flag_wr_i    (flag_wr_i),
    .legacy_ign_i (legacy_ign_i),
    .trap_ud_o    (trap_ud_o),
    .trap_xm_o    (trap_xm_o),
    .commit_o     (commit_o),
    .dest_we_o    (dest_we_o),
    .flags_o      (flags_o),
    .legacy_err_o (legacy_err_o)
);

// File: tb/test_simd_fp_trap_seq.sv
`timescale 1ns/1ps
module test_simd_fp_trap_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 0, flag_wr_i = 0, os_en_i = 1, hdl_ret_i = 0, legacy_ign_i = 0;
    logic [2:0] pre_cond_i = 0, post_cond_i = 0;
    logic [5:0] mask_i = 6'h3f, flag_wr_data_i = 0;
    logic       trap_ud_o, trap_xm_o, commit_o, dest_we_o, legacy_err_o;
    logic [5:0] flags_o;
    int         n_chk = 0, n_err = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    simd_fp_trap_seq i_simd_fp_trap_seq (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic outs(string req, logic ud, logic xm, logic cm);
        chk({req, " trap_ud"}, trap_ud_o, ud);
        chk({req, " trap_xm"}, trap_xm_o, xm);
        chk({req, " commit"}, commit_o, cm);
        chk({req, " dest_we"}, dest_we_o, cm);
        chk({req, " legacy_err"}, legacy_err_o, 1'b0);
    endtask

    task automatic begin_instr(logic [2:0] pre, logic [2:0] post, logic [5:0] msk, logic osen);
        pre_cond_i = pre; post_cond_i = post; mask_i = msk; os_en_i = osen;
        start_i = 1; tick(); start_i = 0;
    endtask

    task automatic ret_handler(); hdl_ret_i = 1; tick(); hdl_ret_i = 0; endtask

    task automatic t_reset();
        outs("R1", 0, 0, 0);
        chk("R1 flags", flags_o, 6'h00);
    endtask

    task automatic t_clean();   // R4, R8
        begin_instr(3'b010, 3'b100, 6'h3f, 1);
        outs("R4 pre", 0, 0, 0); tick();
        outs("R8 post", 0, 0, 0); tick();
        outs("R4 commit", 0, 0, 1);
        chk("R8 flags", flags_o, 6'b100010); tick();
        outs("R4 idle", 0, 0, 0);
    endtask

    task automatic t_pre_trap(); // R2, R11, R5
        flag_wr_i = 1; flag_wr_data_i = 0; tick(); flag_wr_i = 0;
        begin_instr(3'b001, 3'b000, 6'b111110, 1);
        tick();
        outs("R2 trap", 0, 1, 0);
        chk("R2 flags", flags_o, 6'b000001);
        for (int i = 0; i < 6; i++) begin tick(); outs("R11 wait", 0, 0, 0); end
        ret_handler();
        outs("R5 post phase", 0, 0, 0); tick();
        outs("R5 commit", 0, 0, 1); tick();
    endtask

    task automatic t_double(); // R5, R6, R7
        flag_wr_i = 1; flag_wr_data_i = 0; tick(); flag_wr_i = 0;
        begin_instr(3'b001, 3'b011, 6'b110110, 1);
        tick(); outs("R5 first trap", 0, 1, 0);
        ret_handler(); outs("R5 post check", 0, 0, 0);
        tick(); outs("R5 second trap", 0, 1, 0);
        chk("R6 flags OR", flags_o, 6'b011001);
        chk("R7 masked flag", flags_o[4], 1'b1);
        for (int i = 0; i < 3; i++) begin tick(); outs("R7 held", 0, 0, 0); end
        ret_handler(); outs("R7 commit after return", 0, 0, 1); tick();
        outs("R7 idle", 0, 0, 0);
    endtask

    task automatic t_ud();    // R3
        begin_instr(3'b000, 3'b100, 6'b011111, 0);
        tick(); tick(); outs("R3 ud", 1, 0, 0);
        for (int i = 0; i < 4; i++) begin tick(); outs("R3 no commit", 0, 0, 0); end
        begin_instr(3'b100, 3'b000, 6'b111011, 0);
        tick(); outs("R3 pre ud", 1, 0, 0);
        tick(); outs("R3 ended", 0, 0, 0); tick(); outs("R3 ended2", 0, 0, 0);
    endtask

    task automatic t_sticky(); // R9
        flag_wr_i = 1; flag_wr_data_i = 6'b101000; tick(); flag_wr_i = 0;
        chk("R9 write", flags_o, 6'b101000);
        begin_instr(3'b000, 3'b000, 6'h3f, 1);
        tick(); tick(); tick();
        chk("R9 kept", flags_o, 6'b101000);
        begin_instr(3'b010, 3'b000, 6'h3f, 1);
        flag_wr_i = 1; flag_wr_data_i = 6'b000000; tick(); flag_wr_i = 0;
        chk("R9 write plus detect", flags_o, 6'b000010);
        tick(); tick();
    endtask

    task automatic t_legacy(); // R10
        legacy_ign_i = 1;
        begin_instr(3'b000, 3'b000, 6'h3f, 1);
        legacy_ign_i = 0; tick(); legacy_ign_i = 1; tick();
        outs("R10 commit unaffected", 0, 0, 1);
        legacy_ign_i = 0; tick();
        outs("R10 idle", 0, 0, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        t_reset();
        rst = 0; tick();
        t_reset();
        t_clean();
        t_pre_trap();
        t_double();
        t_ud();
        t_sticky();
        t_legacy();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule